// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a multiplexed 32-bit address/data bus and its 4-bit command/byte-enable lines. It watches the transaction framing (FRAME#, IRDY#, TRDY#) and an enable that says whether this agent is driving AD in the current clock. From these it produces the parity bit it must put on PAR, together with the output enable for that bit. It also tells when it must sample PAR coming from another agent and check it.

The parity path is pipelined one clock behind the AD bus. The bit and its enable are registered from the bus value and from the AD enable of the previous clock. Because of this, PAR turns on, turns off and parks one clock after AD does. On the receive side the block captures the 36 bus bits in each address phase, and in each completed data transfer that another agent drives. It compares them with PAR on the next clock and reports a mismatch as a one-clock address-error or data-error pulse.

Top module: `bus_parity_unit`

## Requirements
- R1: `par_o` in each clock equals the XOR of all bits of `ad_i` and `cbe_n_i` as sampled on the previous rising edge, which is even parity over the 36 bits.
- R2: `par_oe_o` equals `ad_oe_i` delayed by exactly one clock. It rises one clock after the AD enable rises and falls one clock after it falls.
- R3: While `rst_n` is low, `par_oe_o`, `par_o`, `addr_perr_o` and `data_perr_o` are all 0.
- R4: An address phase is the first clock with `frame_n_i` low after a clock in which `frame_n_i` and `irdy_n_i` were both high. If `ad_oe_i` is low in that clock, `par_i` is compared on the next edge, and a mismatch sets `addr_perr_o` to 1 one clock later.
- R5: When the command on `cbe_n_i` in the first address phase is the dual-address code 4'b1101, the next clock is a second address phase. It is checked on its own, so either phase can raise `addr_perr_o` without the other.
- R6: A data transfer is any clock, other than an address phase, with `irdy_n_i` and `trdy_n_i` both low. If `ad_oe_i` is low, a parity mismatch on the next clock sets `data_perr_o` to 1 one clock later.
- R7: A phase in which `ad_oe_i` is high is never checked, whatever `par_i` carries.
- R8: Clocks in which `irdy_n_i` or `trdy_n_i` is high are wait states outside an address phase. They are never checked.
- R9: Each error output is high for exactly one clock per failing phase, and it stays low for a phase whose parity is correct. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data bus value in this clock |
| cbe_n_i | input | 4 | Command/byte-enable bus value in this clock |
| frame_n_i | input | 1 | Transaction framing, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| ad_oe_i | input | 1 | This agent drives AD and C/BE# in this clock |
| par_i | input | 1 | PAR value observed on the bus |
| par_o | output | 1 | Parity bit to drive on PAR |
| par_oe_o | output | 1 | Output enable for PAR |
| addr_perr_o | output | 1 | One-clock pulse on an address parity mismatch |
| data_perr_o | output | 1 | One-clock pulse on a data parity mismatch |

## Verification
The bench builds the block with its defaults: a 32-bit AD bus, 4-bit C/BE# and dual-address code 4'b1101. At those widths the byte-lane parity tree has five lanes, including a padded partial lane for the C/BE# bits, so walking-one and dense patterns reach every lane. The dual-address code is used as a real command, which lets the bench corrupt each of the two address phases on its own. Data sequences put wait states that carry bad parity between real transfers, to show that only completed transfers are checked.

// File: rtl/bus_parity_pkg.sv
package bus_parity_pkg;

  typedef enum logic [1:0] {
    PH_NONE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  localparam int LANE_W = 8;

endpackage

// File: rtl/bpu_parity_tree.sv
module bpu_parity_tree
  import bus_parity_pkg::*;
#(
  parameter int W = 36
) (
  input  logic [W-1:0] din,
  output logic         par
);

  localparam int LANES = (W + LANE_W - 1) / LANE_W;
  localparam int PW    = LANES * LANE_W;

  logic [PW-1:0]    padded;
  logic [LANES-1:0] lane_par;

  always_comb begin
    padded        = '0;
    padded[W-1:0] = din;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^padded[g*LANE_W +: LANE_W];
  end

  assign par = ^lane_par;

endmodule

// File: rtl/bpu_phase_track.sv
module bpu_phase_track
  import bus_parity_pkg::*;
#(
  parameter int               CBE_W   = 4,
  parameter logic [CBE_W-1:0] DAC_CMD = 4'b1101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             trdy_n,
  input  logic [CBE_W-1:0] cbe_n,
  output phase_e           phase
);

  logic idle_q, idle_d;
  logic dac_q, dac_d;
  logic first_addr;

  // first address clock: framing starts after a fully idle clock
  assign first_addr = !frame_n && idle_q;

  always_comb begin
    idle_d = frame_n && irdy_n;
    dac_d  = first_addr && (cbe_n == DAC_CMD);
  end

  always_comb begin
    if (first_addr || dac_q)
      phase = PH_ADDR;
    else if (!irdy_n && !trdy_n)
      phase = PH_DATA;
    else
      phase = PH_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= 1'b1;
      dac_q  <= 1'b0;
    end else begin
      idle_q <= idle_d;
      dac_q  <= dac_d;
    end
  end

endmodule

// File: rtl/bpu_checker.sv
module bpu_checker
  import bus_parity_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_e phase,
  input  logic   drive_oe,
  input  logic   calc_par,
  input  logic   bus_par,
  output logic   addr_err,
  output logic   data_err
);

  logic cap_addr_q, cap_addr_d;
  logic cap_data_q, cap_data_d;
  logic cap_par_q, cap_par_d;
  logic cap_en;
  logic aerr_q, aerr_d;
  logic derr_q, derr_d;
  logic mismatch;

  // capture stage: only phases another agent drives
  always_comb begin
    cap_addr_d = (phase == PH_ADDR) && !drive_oe;
    cap_data_d = (phase == PH_DATA) && !drive_oe;
    cap_en     = cap_addr_d || cap_data_d;
    cap_par_d  = cap_en ? calc_par : cap_par_q;
  end

  // compare stage: PAR arrives one clock after the captured bits
  always_comb begin
    mismatch = cap_par_q ^ bus_par;
    aerr_d   = cap_addr_q && mismatch;
    derr_d   = cap_data_q && mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= 1'b0;
      cap_data_q <= 1'b0;
      cap_par_q  <= 1'b0;
      aerr_q     <= 1'b0;
      derr_q     <= 1'b0;
    end else begin
      cap_addr_q <= cap_addr_d;
      cap_data_q <= cap_data_d;
      cap_par_q  <= cap_par_d;
      aerr_q     <= aerr_d;
      derr_q     <= derr_d;
    end
  end

  assign addr_err = aerr_q;
  assign data_err = derr_q;

endmodule

// File: rtl/bus_parity_unit.sv
module bus_parity_unit
  import bus_parity_pkg::*;
#(
  parameter int                AD_W    = 32,
  parameter int                CBE_W   = 4,
  parameter logic [CBE_W-1:0]  DAC_CMD = 4'b1101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_n_i,
  input  logic             frame_n_i,
  input  logic             irdy_n_i,
  input  logic             trdy_n_i,
  input  logic             ad_oe_i,
  input  logic             par_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             addr_perr_o,
  output logic             data_perr_o
);

  localparam int BUS_W = AD_W + CBE_W;

  logic   bus_par;
  phase_e phase;
  logic   par_q, par_d;
  logic   oe_q, oe_d;

  bpu_parity_tree #(.W(BUS_W)) u_tree (
    .din ({cbe_n_i, ad_i}),
    .par (bus_par)
  );

  bpu_phase_track #(.CBE_W(CBE_W), .DAC_CMD(DAC_CMD)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n_i),
    .irdy_n  (irdy_n_i),
    .trdy_n  (trdy_n_i),
    .cbe_n   (cbe_n_i),
    .phase   (phase)
  );

  bpu_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (phase),
    .drive_oe (ad_oe_i),
    .calc_par (bus_par),
    .bus_par  (par_i),
    .addr_err (addr_perr_o),
    .data_err (data_perr_o)
  );

  // generator: value and enable both trail AD by one clock
  always_comb begin
    par_d = bus_par;
    oe_d  = ad_oe_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      par_q <= par_d;
      oe_q  <= oe_d;
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = oe_q;

endmodule

// File: rtl/bus_parity_unit_sva.sv
module bus_parity_unit_sva #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AD_W-1:0]  ad_i,
  input logic [CBE_W-1:0] cbe_n_i,
  input logic             irdy_n_i,
  input logic             trdy_n_i,
  input logic             ad_oe_i,
  input logic             par_o,
  input logic             par_oe_o,
  input logic             addr_perr_o,
  input logic             data_perr_o
);

  logic [1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hist <= 2'd0;
    else if (hist != 2'd3)
      hist <= hist + 2'd1;
  end

  assert_par_lag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hist != 2'd0) |-> (par_o == ^$past({cbe_n_i, ad_i})));

  assert_oe_lag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hist != 2'd0) |-> (par_oe_o == $past(ad_oe_i)));

  assert_own_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist >= 2'd2) && (addr_perr_o || data_perr_o)) |-> !$past(ad_oe_i, 2));

  assert_wait_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((hist >= 2'd2) && data_perr_o) |-> $past(!irdy_n_i && !trdy_n_i, 2));

  assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_perr_o && data_perr_o));

endmodule

bind bus_parity_unit bus_parity_unit_sva #(.AD_W(AD_W), .CBE_W(CBE_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .ad_i        (ad_i),
  .cbe_n_i     (cbe_n_i),
  .irdy_n_i    (irdy_n_i),
  .trdy_n_i    (trdy_n_i),
  .ad_oe_i     (ad_oe_i),
  .par_o       (par_o),
  .par_oe_o    (par_oe_o),
  .addr_perr_o (addr_perr_o),
  .data_perr_o (data_perr_o)
);

// File: tb/bus_parity_unit_tb.sv
`timescale 1ns/1ps
module bus_parity_unit_tb;

  logic        clk;
  logic        rst_n;
  logic [31:0] ad;
  logic [3:0]  cbe;
  logic        frame_n, irdy_n, trdy_n, oe, par_in;
  logic        par_o, par_oe_o, addr_perr_o, data_perr_o;

  int vec_cnt  = 0;
  int miss_cnt = 0;

  bus_parity_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ad_i        (ad),
    .cbe_n_i     (cbe),
    .frame_n_i   (frame_n),
    .irdy_n_i    (irdy_n),
    .trdy_n_i    (trdy_n),
    .ad_oe_i     (oe),
    .par_i       (par_in),
    .par_o       (par_o),
    .par_oe_o    (par_oe_o),
    .addr_perr_o (addr_perr_o),
    .data_perr_o (data_perr_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic epar(input logic [31:0] a, input logic [3:0] c);
    logic p;
    p = 1'b0;
    for (int i = 0; i < 32; i++) p = p ^ a[i];
    for (int i = 0; i < 4; i++)  p = p ^ c[i];
    return p;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      miss_cnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // advance one edge, then settle away from it
  task automatic step();
    @(posedge clk);
    #5;
  endtask

  task automatic bus_idle();
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    oe = 1'b0; ad = '0; cbe = '0; par_in = 1'b0;
    step();
    step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    bus_idle();
    chk("R3 par_oe", par_oe_o, 0);
    chk("R3 par", par_o, 0);
    chk("R3 aerr", addr_perr_o, 0);
    chk("R3 derr", data_perr_o, 0);
    #3 rst_n = 1'b1;
    step();
  endtask

  task automatic t_generate();
    logic [31:0] pat;
    logic [3:0]  c;
    oe = 1'b1;
    for (int i = 0; i < 40; i++) begin
      pat = (i < 32) ? (32'h1 << i) : (32'hA5C3_0F96 * i);
      c   = 4'(i * 3);
      ad = pat; cbe = c;
      step();
      chk("R1 par value", par_o, epar(pat, c));
      chk("R2 oe on", par_oe_o, 1);
    end
    ad = 32'hFFFF_FFFF; cbe = 4'hF;
    step();
    chk("R1 all ones", par_o, 0);
    oe = 1'b0;
    #2 chk("R2 oe held one clock", par_oe_o, 1);
    step();
    chk("R2 oe off after lag", par_oe_o, 0);
    bus_idle();
  endtask

  task automatic t_addr(input logic [31:0] a, input logic bad);
    frame_n = 1'b0; ad = a; cbe = 4'b0110; oe = 1'b0;
    step();
    par_in = epar(a, 4'b0110) ^ bad;
    ad = '0; cbe = '0;
    step();
    chk("R4 addr err", addr_perr_o, bad);
    chk("R9 no data err", data_perr_o, 0);
    frame_n = 1'b1; par_in = 1'b0;
    step();
    chk("R9 addr pulse width", addr_perr_o, 0);
    bus_idle();
  endtask

  task automatic t_dual(input logic bad1, input logic bad2);
    frame_n = 1'b0; oe = 1'b0;
    ad = 32'h1234_5678; cbe = 4'b1101;
    step();
    par_in = epar(32'h1234_5678, 4'b1101) ^ bad1;
    ad = 32'h0000_00F1; cbe = 4'b0110;
    step();
    chk("R5 first addr", addr_perr_o, bad1);
    par_in = epar(32'h0000_00F1, 4'b0110) ^ bad2;
    ad = '0; cbe = '0;
    step();
    chk("R5 second addr", addr_perr_o, bad2);
    frame_n = 1'b1; par_in = 1'b0;
    step();
    chk("R9 after dual", addr_perr_o, 0);
    bus_idle();
  endtask

  task automatic t_data();
    frame_n = 1'b0; oe = 1'b0; ad = 32'h8000_0040; cbe = 4'b0110;
    step();
    par_in = epar(32'h8000_0040, 4'b0110);
    irdy_n = 1'b0; trdy_n = 1'b1; ad = 32'hDEAD_BEEF; cbe = 4'h0;
    step();
    chk("R4 good addr no err", addr_perr_o, 0);
    par_in = epar(32'hDEAD_BEEF, 4'h0) ^ 1'b1;
    trdy_n = 1'b0; ad = 32'h0BAD_F00D;
    step();
    chk("R8 wait not checked", data_perr_o, 0);
    par_in = epar(32'h0BAD_F00D, 4'h0) ^ 1'b1;
    frame_n = 1'b1; ad = 32'h0000_0003;
    step();
    chk("R6 data err", data_perr_o, 1);
    chk("R9 exclusive", addr_perr_o, 0);
    par_in = epar(32'h0000_0003, 4'h0);
    irdy_n = 1'b1; trdy_n = 1'b1; ad = '0;
    step();
    chk("R6 good data no err", data_perr_o, 0);
    step();
    chk("R9 data pulse width", data_perr_o, 0);
    bus_idle();
  endtask

  task automatic t_own_drive();
    frame_n = 1'b0; oe = 1'b1; ad = 32'h00C0_FFEE; cbe = 4'b0111;
    step();
    par_in = ~epar(32'h00C0_FFEE, 4'b0111);
    irdy_n = 1'b0; trdy_n = 1'b0; ad = 32'h7777_0001; cbe = 4'h0;
    frame_n = 1'b1;
    step();
    chk("R7 own addr unchecked", addr_perr_o, 0);
    par_in = ~epar(32'h7777_0001, 4'h0);
    irdy_n = 1'b1; trdy_n = 1'b1; ad = '0;
    step();
    chk("R7 own data unchecked", data_perr_o, 0);
    chk("R7 own addr still quiet", addr_perr_o, 0);
    bus_idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    oe = 1'b0; ad = '0; cbe = '0; par_in = 1'b0;
    #5;
    t_reset();
    t_generate();
    t_addr(32'h0000_1000, 1'b0);
    t_addr(32'hFFFF_0000, 1'b1);
    t_dual(1'b1, 1'b0);
    t_dual(1'b0, 1'b1);
    t_data();
    t_own_drive();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
    $finish;
  end

endmodule